// File: doc/BRIEF.md
# Irregular-Sequence Synchronous Counter

This block is a four-bit synchronous counter whose state walks a fixed, non-binary loop of seven values: 2, 3, 5, 7, 10, 12, 14. After 14 it returns to 2. All four state bits sit in D-type registers that share one rising clock edge. A case decode of the present state drives the data inputs of those registers directly.

The counter has no enable, load or direction control. It runs on every clock edge while reset is low. A synchronous, active-high reset puts the state at 2.

Any code outside the loop is sent to 6 on the next edge. Six is not in the loop, so the counter stays at 6 until reset. This lets a corrupted state settle into one known, easily detected code.

Top module: `irr_seq_counter`

## Requirements
- R1: With `rst` high at a rising edge of `clk`, `count_o` is 2 after that edge.
- R2: With `rst` low, each rising edge moves the state one step along the loop: 2 goes to 3, 3 to 5, 5 to 7, 7 to 10, 10 to 12, and 12 to 14.
- R3: With `rst` low, state 14 goes to 2 on the next rising edge, so the loop repeats without end.
- R4: With `rst` low, each code outside both the loop and 6 (0, 1, 4, 8, 9, 11, 13, 15) goes to 6 on the next rising edge.
- R5: With `rst` low, state 6 goes to 6 on every edge, so only reset can leave it.
- R6: Reset takes priority over counting. Asserting `rst` at any point in the loop gives 2 after the edge, and counting resumes from 2 on the first edge with `rst` low.
- R7: After the first reset, with no further corruption, `count_o` only ever shows values from the loop, because all four bits change on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state bits |
| rst | input | 1 | Synchronous active-high reset; loads 2 |
| count_o | output | 4 | Present counter state |

## Verification
The clocked assertions assume that `rst` is a clean, synchronous level sampled at the rising edge. They also assume the state is undefined until the first reset, so they stay quiet until a reset has been seen.

The bench drives `rst` only half a period away from the rising edge. It holds `rst` high for the first cycles, and after that it pulses `rst` at random points in the loop.

The top has no load port, so the state stays inside the loop. The recovery codes and the lock code 6 are therefore covered by feeding all sixteen codes into the next-state decode unit on its own.

// File: rtl/irr_seq_pkg.sv
package irr_seq_pkg;

    localparam int STATE_W = 4;

    typedef logic [STATE_W-1:0] code_t;

    typedef enum code_t {
        ST_A    = 4'd2,
        ST_B    = 4'd3,
        ST_C    = 4'd5,
        ST_D    = 4'd7,
        ST_E    = 4'd10,
        ST_F    = 4'd12,
        ST_G    = 4'd14,
        ST_TRAP = 4'd6
    } seq_state_e;

    localparam code_t RESET_CODE = code_t'(ST_A);
    localparam code_t TRAP_CODE  = code_t'(ST_TRAP);

    // Membership in the seven-value loop.
    function automatic logic in_loop(input code_t c);
        case (c)
            4'd2, 4'd3, 4'd5, 4'd7, 4'd10, 4'd12, 4'd14: in_loop = 1'b1;
            default:                                     in_loop = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irr_seq_next.sv
module irr_seq_next
    import irr_seq_pkg::*;
(
    input  code_t cur_i,
    output code_t nxt_o
);

    always_comb begin
        case (cur_i)
            code_t'(ST_A): nxt_o = code_t'(ST_B);
            code_t'(ST_B): nxt_o = code_t'(ST_C);
            code_t'(ST_C): nxt_o = code_t'(ST_D);
            code_t'(ST_D): nxt_o = code_t'(ST_E);
            code_t'(ST_E): nxt_o = code_t'(ST_F);
            code_t'(ST_F): nxt_o = code_t'(ST_G);
            code_t'(ST_G): nxt_o = code_t'(ST_A);
            default:       nxt_o = TRAP_CODE;   // recovery and lock (R4, R5)
        endcase
    end

    // R4/R5: a code outside the loop always leads to the trap code
    always_comb begin
        if (!$isunknown(cur_i))
            assert_offloop_to_trap_R4: assert (in_loop(cur_i) || nxt_o == TRAP_CODE);
    end

    // R2/R3: a loop code never leads outside the loop
    always_comb begin
        if (!$isunknown(cur_i))
            assert_loop_closed_R2: assert (!in_loop(cur_i) || in_loop(nxt_o));
    end

endmodule

// File: rtl/irr_seq_reg.sv
module irr_seq_reg
    import irr_seq_pkg::*;
#(
    parameter int    W        = STATE_W,
    parameter code_t INIT_VAL = RESET_CODE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // One D flip-flop per state bit, all on the same edge.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q_o[b] <= INIT_VAL[b];
            else     q_o[b] <= d_i[b];
        end
    end

endmodule

// File: rtl/irr_seq_counter.sv
module irr_seq_counter
    import irr_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    output logic [3:0]   count_o
);

    code_t state_q;
    code_t state_d;

    irr_seq_next u_next (
        .cur_i (state_q),
        .nxt_o (state_d)
    );

    irr_seq_reg #(
        .W        (STATE_W),
        .INIT_VAL (RESET_CODE)
    ) u_reg (
        .clk (clk),
        .rst (rst),
        .d_i (state_d),
        .q_o (state_q)
    );

    assign count_o = state_q;

    // Arms the clocked checks once a reset has been seen.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b1;
    end

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> (count_o == RESET_CODE));

    assert_step_2_to_3_R2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (count_o == 4'd2) |=> (count_o == 4'd3));

    assert_step_12_to_14_R2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (count_o == 4'd12) |=> (count_o == 4'd14));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (count_o == 4'd14) |=> (count_o == 4'd2));

    assert_trap_hold_R5: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (count_o == TRAP_CODE) |=> (count_o == TRAP_CODE));

    assert_stays_in_loop_R7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        in_loop(count_o) |=> in_loop(count_o));

endmodule

// File: tb/sim_irr_seq_counter.sv
module sim_irr_seq_counter;
    import irr_seq_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] count_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irr_seq_counter u0 (
        .clk     (clk),
        .rst     (rst),
        .count_o (count_o)
    );

    // Decode unit on its own, to reach codes the top cannot enter.
    code_t dec_in = '0;
    code_t dec_out;
    irr_seq_next u1 (.cur_i(dec_in), .nxt_o(dec_out));

    // Expected successor, written from the requirements.
    function automatic logic [3:0] ref_succ(input logic [3:0] c);
        logic [3:0] loop_vals [7] = '{4'd2, 4'd3, 4'd5, 4'd7, 4'd10, 4'd12, 4'd14};
        for (int i = 0; i < 7; i++)
            if (loop_vals[i] == c) return loop_vals[(i + 1) % 7];
        return 4'd6;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Bench-side model of the counter.
    logic [3:0] model = 4'd0;
    always @(posedge clk) model <= rst ? 4'd2 : ref_succ(model);

    initial begin
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", count_o, 4'd2);
        rst = 1'b0;

        // R2, R3: one full lap and a bit, directed
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            check((model == 4'd2) ? "R3" : "R2", count_o, model);
        end

        // R6: reset in the middle of the loop
        rst = 1'b1;
        @(negedge clk);
        check("R6", count_o, 4'd2);
        rst = 1'b0;
        @(negedge clk);
        check("R6", count_o, 4'd3);

        // Random reset pulses, R2/R3/R6/R7 against the model
        for (int k = 0; k < 400; k++) begin
            rst = (($urandom % 9) == 0);
            @(negedge clk);
            check("R7", count_o, model);
        end
        rst = 1'b0;

        // R4, R5: sweep every code through the decode unit
        for (int c = 0; c < 16; c++) begin
            dec_in = code_t'(c);
            #1;
            if (c == 6)
                check("R5", dec_out, 4'd6);
            else if (c inside {0, 1, 4, 8, 9, 11, 13, 15})
                check("R4", dec_out, 4'd6);
            else
                check((c == 14) ? "R3" : "R2", dec_out, ref_succ(4'(c)));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule